// File: doc/BRIEF.md
# Operand Effective Address Generator

This block computes the memory address of one instruction operand. It serves a processor core with a complex instruction set. A request carries the following:
- an addressing-mode code
- an operand size
- the value of the base address register
- an index register value
- the program counter
- a 16-bit displacement, an 8-bit displacement and a 32-bit absolute extension word

All of these are sampled on the clock edge where `start` is high. One cycle later the block presents the registered effective address together with a `done` pulse.

For the two auto-modify modes, the block also returns the updated base register value and a write-back strobe. The size of the step follows the operand size. The same request also turns a 3-bit quick-immediate opcode field into its operand value. In add-quick and subtract-quick use, a zero field means eight.

The control is a two-state machine:
- **IDLE** waits for a request. The `start` transition goes to DONE.
- **DONE** presents the result for one cycle. It moves to DONE again on a new `start` (back-to-back requests), and otherwise returns to IDLE.

Results stay on the outputs until the next request.

Top module: `eagu_top`

## Requirements
- R1: `done` is high exactly in the cycle after a clock edge that sampled `start` high (state DONE). The registered outputs `ea`, `an_next` and `quick_val` keep their values until the next such edge.
- R2: Mode 0 (register indirect): `ea` equals `an`.
- R3: Mode 1 (post-increment): `ea` equals the old `an`, and `an_next` equals `an` plus the step.
- R4: Mode 2 (pre-decrement): `an_next` equals `an` minus the step, and `ea` equals that new value.
- R5: The step is selected by `size`: `size` 00 (byte) gives 1, 01 (word) gives 2, and 10 or 11 (long) give 4. Arithmetic wraps modulo 2^32.
- R6: Mode 3: `ea` equals `an` plus the sign-extended `disp16`.
- R7: Mode 4: `ea` equals `an` plus the index plus the sign-extended `disp8`. The index is the full `xn` when `x_long` is 1, and the sign-extended `xn[15:0]` when it is 0.
- R8: Mode 5 gives `pc` plus the sign-extended `disp16`. Mode 6 gives `pc` plus the index (as in R7) plus the sign-extended `disp8`.
- R9: Mode 7 gives the sign-extended `ext[15:0]`. Mode 8 gives `ext` unchanged.
- R10: `an_we` is high only in a DONE cycle whose request used mode 1 or 2. For every other mode, `an_next` equals the sampled `an`. Codes 9 to 15 give `ea` = 0.
- R11: `quick_val` is `quick_field` zero-extended to 4 bits. The exception is `quick_addsub` = 1 with a field of 0, which gives 8.
- R12: During and after reset: `done` = 0, `an_we` = 0, `ea` = 0, `an_next` = 0 and `quick_val` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe; all other inputs are sampled with it |
| mode | input | 4 | Addressing-mode code (0..8) |
| size | input | 2 | Operand size: 00 byte, 01 word, 1x long |
| an | input | 32 | Base address register value |
| xn | input | 32 | Index register value |
| x_long | input | 1 | 1: full index, 0: sign-extended low word |
| pc | input | 32 | Program counter base |
| disp16 | input | 16 | 16-bit signed displacement |
| disp8 | input | 8 | 8-bit signed displacement |
| ext | input | 32 | Absolute address extension word(s) |
| quick_field | input | 3 | Quick-immediate opcode field |
| quick_addsub | input | 1 | 1 when the quick field belongs to an add/subtract-quick |
| done | output | 1 | Result valid pulse |
| ea | output | 32 | Effective address |
| an_next | output | 32 | Updated base register value |
| an_we | output | 1 | Base register write-back enable |
| quick_val | output | 4 | Quick-immediate operand value |

## Verification
Every result of this block is due on the first rising edge after the edge that samples `start`. The address, the updated register, the write strobe, the quick value and `done` all appear together. No result is due later than that.

The bench changes inputs on falling edges and raises `start` for exactly one edge. It then samples all outputs at the following falling edge. For the "held" and "pulse ends" checks, it samples once more a cycle later.

A back-to-back case keeps `start` high on two edges in a row. This confirms that the second result replaces the first at the second following edge while `done` stays high.

// File: rtl/eagu_pkg.sv
package eagu_pkg;

    typedef enum logic [3:0] {
        EA_IND      = 4'd0,
        EA_POSTINC  = 4'd1,
        EA_PREDEC   = 4'd2,
        EA_DISP16   = 4'd3,
        EA_INDEX    = 4'd4,
        EA_PC_DISP  = 4'd5,
        EA_PC_INDEX = 4'd6,
        EA_ABS16    = 4'd7,
        EA_ABS32    = 4'd8
    } ea_mode_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } ctl_state_e;

endpackage

// File: rtl/eagu_addr_calc.sv
module eagu_addr_calc
    import eagu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LDISP_W = 16,
    parameter int SDISP_W = 8
) (
    input  logic [3:0]         mode,
    input  logic [1:0]         size,
    input  logic [AW-1:0]      an,
    input  logic [AW-1:0]      xn,
    input  logic               x_long,
    input  logic [AW-1:0]      pc,
    input  logic [LDISP_W-1:0] disp16,
    input  logic [SDISP_W-1:0] disp8,
    input  logic [AW-1:0]      ext,
    output logic [AW-1:0]      ea_c,
    output logic [AW-1:0]      an_c,
    output logic               wb_c
);
    localparam int HALF_W = AW / 2;

    logic [AW-1:0] step;
    logic [AW-1:0] idx;
    logic [AW-1:0] ldisp_x;
    logic [AW-1:0] sdisp_x;
    logic [AW-1:0] abs_short_x;
    logic [AW-1:0] an_dec;

    // Step chosen by operand size: byte 1, word 2, long 4
    always_comb begin
        unique case (size)
            2'b00:   step = AW'(1);
            2'b01:   step = AW'(2);
            default: step = AW'(4);
        endcase
    end

    assign idx         = x_long ? xn : {{(AW-HALF_W){xn[HALF_W-1]}}, xn[HALF_W-1:0]};
    assign ldisp_x     = {{(AW-LDISP_W){disp16[LDISP_W-1]}}, disp16};
    assign sdisp_x     = {{(AW-SDISP_W){disp8[SDISP_W-1]}}, disp8};
    assign abs_short_x = {{(AW-LDISP_W){ext[LDISP_W-1]}}, ext[LDISP_W-1:0]};
    assign an_dec      = an - step;

    always_comb begin
        ea_c = '0;
        an_c = an;
        wb_c = 1'b0;
        unique case (mode)
            EA_IND:      ea_c = an;
            EA_POSTINC: begin
                ea_c = an;
                an_c = an + step;
                wb_c = 1'b1;
            end
            EA_PREDEC: begin
                ea_c = an_dec;
                an_c = an_dec;
                wb_c = 1'b1;
            end
            EA_DISP16:   ea_c = an + ldisp_x;
            EA_INDEX:    ea_c = an + idx + sdisp_x;
            EA_PC_DISP:  ea_c = pc + ldisp_x;
            EA_PC_INDEX: ea_c = pc + idx + sdisp_x;
            EA_ABS16:    ea_c = abs_short_x;
            EA_ABS32:    ea_c = ext;
            default:     ea_c = '0;
        endcase
    end
endmodule

// File: rtl/eagu_quick.sv
module eagu_quick #(
    parameter int QW = 3
) (
    input  logic [QW-1:0] field,
    input  logic          addsub,
    output logic [QW:0]   value
);
    // A zero field in add/subtract-quick stands for 2**QW
    always_comb begin
        if (addsub && (field == '0)) value = (QW+1)'(1 << QW);
        else                         value = {1'b0, field};
    end
endmodule

// File: rtl/eagu_top.sv
module eagu_top
    import eagu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int LDISP_W = 16,
    parameter int SDISP_W = 8,
    parameter int QW      = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [3:0]         mode,
    input  logic [1:0]         size,
    input  logic [AW-1:0]      an,
    input  logic [AW-1:0]      xn,
    input  logic               x_long,
    input  logic [AW-1:0]      pc,
    input  logic [LDISP_W-1:0] disp16,
    input  logic [SDISP_W-1:0] disp8,
    input  logic [AW-1:0]      ext,
    input  logic [QW-1:0]      quick_field,
    input  logic               quick_addsub,
    output logic               done,
    output logic [AW-1:0]      ea,
    output logic [AW-1:0]      an_next,
    output logic               an_we,
    output logic [QW:0]        quick_val
);
    ctl_state_e    state_q, state_d;
    logic [AW-1:0] ea_c, an_c;
    logic          wb_c, wb_q;
    logic [QW:0]   quick_c;

    eagu_addr_calc #(.AW(AW), .LDISP_W(LDISP_W), .SDISP_W(SDISP_W)) u_calc (
        .mode(mode), .size(size), .an(an), .xn(xn), .x_long(x_long),
        .pc(pc), .disp16(disp16), .disp8(disp8), .ext(ext),
        .ea_c(ea_c), .an_c(an_c), .wb_c(wb_c)
    );

    eagu_quick #(.QW(QW)) u_quick (
        .field(quick_field), .addsub(quick_addsub), .value(quick_c)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = start ? ST_DONE : ST_IDLE;
            ST_DONE: state_d = start ? ST_DONE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Result registers, loaded on each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea        <= '0;
            an_next   <= '0;
            wb_q      <= 1'b0;
            quick_val <= '0;
        end else if (start) begin
            ea        <= ea_c;
            an_next   <= an_c;
            wb_q      <= wb_c;
            quick_val <= quick_c;
        end
    end

    assign done  = (state_q == ST_DONE);
    assign an_we = done && wb_q;

    logic [AW-1:0] post_gap;
    assign post_gap = an_next - ea;

    AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done); // R1
    AST_NO_SPURIOUS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !done); // R1
    AST_HOLD_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(ea) && $stable(an_next)); // R1
    AST_POSTINC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == EA_POSTINC) |=> an_we && ($countones(post_gap) == 1) && (post_gap <= AW'(4))); // R3
    AST_PREDEC_USES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode == EA_PREDEC) |=> an_we && (ea == an_next)); // R4
    AST_WE_ONLY_AUTOMOD: assert property (@(posedge clk) disable iff (!rst_n)
        (start && mode != EA_POSTINC && mode != EA_PREDEC) |=> !an_we); // R10
    AST_WE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        an_we |-> done); // R10
    AST_QUICK_ZERO_IS_EIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        (start && quick_addsub && quick_field == '0) |=> quick_val == (QW+1)'(1 << QW)); // R11
endmodule

// File: tb/eagu_top_bench.sv
module eagu_top_bench;
    typedef struct packed {
        logic [3:0]  mode;
        logic [1:0]  size;
        logic [31:0] an;
        logic [31:0] xn;
        logic        xl;
        logic [31:0] pc;
        logic [15:0] d16;
        logic [7:0]  d8;
        logic [31:0] ext;
        logic [31:0] e_ea;
        logic [31:0] e_an;
        logic        e_we;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // mode size an xn xl pc d16 d8 ext | ea an_next we
        '{4'd0, 2'b01, 32'h0000_1000, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'h0, 32'h0000_1000, 32'h0000_1000, 1'b0}, // R2
        '{4'd1, 2'b00, 32'h0000_1000, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'h0, 32'h0000_1000, 32'h0000_1001, 1'b1}, // R3 R5
        '{4'd1, 2'b01, 32'h0000_2000, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'h0, 32'h0000_2000, 32'h0000_2002, 1'b1}, // R3 R5
        '{4'd1, 2'b10, 32'hFFFF_FFFE, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'h0, 32'hFFFF_FFFE, 32'h0000_0002, 1'b1}, // R3 R5 wrap
        '{4'd2, 2'b00, 32'h0000_1000, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'h0, 32'h0000_0FFF, 32'h0000_0FFF, 1'b1}, // R4
        '{4'd2, 2'b10, 32'h0000_1000, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'h0, 32'h0000_0FFC, 32'h0000_0FFC, 1'b1}, // R4 R5
        '{4'd2, 2'b11, 32'h0000_1000, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'h0, 32'h0000_0FFC, 32'h0000_0FFC, 1'b1}, // R5
        '{4'd3, 2'b01, 32'h0000_1000, 32'h0, 1'b0, 32'h0, 16'hFFFE, 8'h0, 32'h0, 32'h0000_0FFE, 32'h0000_1000, 1'b0}, // R6
        '{4'd3, 2'b01, 32'h0000_1000, 32'h0, 1'b0, 32'h0, 16'h7FFF, 8'h0, 32'h0, 32'h0000_8FFF, 32'h0000_1000, 1'b0}, // R6
        '{4'd4, 2'b01, 32'h0000_1000, 32'h0001_FFF0, 1'b0, 32'h0, 16'h0, 8'h05, 32'h0, 32'h0000_0FF5, 32'h0000_1000, 1'b0}, // R7
        '{4'd4, 2'b01, 32'h0000_1000, 32'h0001_FFF0, 1'b1, 32'h0, 16'h0, 8'h05, 32'h0, 32'h0002_0FF5, 32'h0000_1000, 1'b0}, // R7
        '{4'd4, 2'b01, 32'h0000_1000, 32'h0000_0010, 1'b0, 32'h0, 16'h0, 8'h80, 32'h0, 32'h0000_0F90, 32'h0000_1000, 1'b0}, // R7
        '{4'd5, 2'b01, 32'h0000_1234, 32'h0, 1'b0, 32'h0000_4000, 16'h8000, 8'h0, 32'h0, 32'hFFFF_C000, 32'h0000_1234, 1'b0}, // R8
        '{4'd6, 2'b01, 32'h0000_1234, 32'hFFFF_FFFF, 1'b1, 32'h0000_4000, 16'h0, 8'h02, 32'h0, 32'h0000_4001, 32'h0000_1234, 1'b0}, // R8
        '{4'd7, 2'b01, 32'h0000_1234, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'h0000_8000, 32'hFFFF_8000, 32'h0000_1234, 1'b0}, // R9
        '{4'd7, 2'b01, 32'h0000_1234, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'hABCD_1234, 32'h0000_1234, 32'h0000_1234, 1'b0}, // R9
        '{4'd8, 2'b01, 32'h0000_1234, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'hABCD_1234, 32'hABCD_1234, 32'h0000_1234, 1'b0}, // R9
        '{4'd15, 2'b01, 32'h0000_5555, 32'h0, 1'b0, 32'h0, 16'h0, 8'h0, 32'hABCD_1234, 32'h0, 32'h0000_5555, 1'b0}  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [1:0]  size = '0;
    logic [31:0] an = '0, xn = '0, pc = '0, ext = '0;
    logic        x_long = 1'b0;
    logic [15:0] disp16 = '0;
    logic [7:0]  disp8 = '0;
    logic [2:0]  quick_field = '0;
    logic        quick_addsub = 1'b0;
    logic        done, an_we;
    logic [31:0] ea, an_next;
    logic [3:0]  quick_val;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    eagu_top u_eagu_top (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size(size),
        .an(an), .xn(xn), .x_long(x_long), .pc(pc), .disp16(disp16),
        .disp8(disp8), .ext(ext), .quick_field(quick_field),
        .quick_addsub(quick_addsub), .done(done), .ea(ea), .an_next(an_next),
        .an_we(an_we), .quick_val(quick_val)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_vec(input vec_t v);
        mode = v.mode; size = v.size; an = v.an; xn = v.xn; x_long = v.xl;
        pc = v.pc; disp16 = v.d16; disp8 = v.d8; ext = v.ext;
    endtask

    task automatic quick_case(input logic [2:0] f, input logic as, input logic [3:0] exp);
        @(negedge clk);
        quick_field = f; quick_addsub = as; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", "quick_val", {28'h0, quick_val}, {28'h0, exp});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset values
        chk("R12", "done", {31'h0, done}, 32'h0);
        chk("R12", "an_we", {31'h0, an_we}, 32'h0);
        chk("R12", "ea", ea, 32'h0);
        chk("R12", "an_next", an_next, 32'h0);
        chk("R12", "quick_val", {28'h0, quick_val}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle done", {31'h0, done}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            load_vec(VECS[i]);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            chk("R1", $sformatf("v%0d done", i), {31'h0, done}, 32'h1);
            chk("R2-9", $sformatf("v%0d ea", i), ea, VECS[i].e_ea);
            chk("R10", $sformatf("v%0d an_next", i), an_next, VECS[i].e_an);
            chk("R10", $sformatf("v%0d an_we", i), {31'h0, an_we}, {31'h0, VECS[i].e_we});
        end

        // R1: pulse ends, values held while inputs change
        load_vec(VECS[1]);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        an = 32'hDEAD_0000;
        mode = 4'd8;
        @(negedge clk);
        chk("R1", "pulse end done", {31'h0, done}, 32'h0);
        chk("R10", "we low without done", {31'h0, an_we}, 32'h0);
        chk("R1", "held ea", ea, 32'h0000_1000);
        chk("R1", "held an_next", an_next, 32'h0000_1001);

        // R1: back-to-back requests
        load_vec(VECS[4]);
        start = 1'b1;
        @(negedge clk);
        chk("R4", "b2b first ea", ea, 32'h0000_0FFF);
        load_vec(VECS[16]);
        @(negedge clk);
        start = 1'b0;
        chk("R1", "b2b done stays", {31'h0, done}, 32'h1);
        chk("R9", "b2b second ea", ea, 32'hABCD_1234);
        chk("R10", "b2b second we", {31'h0, an_we}, 32'h0);

        // R11: quick immediate
        quick_case(3'd0, 1'b1, 4'd8);
        quick_case(3'd0, 1'b0, 4'd0);
        quick_case(3'd5, 1'b1, 4'd5);
        quick_case(3'd7, 1'b1, 4'd7);
        quick_case(3'd1, 1'b0, 4'd1);

        // R12: reset mid-operation clears results
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R12", "ea after reset", ea, 32'h0);
        chk("R12", "quick after reset", {28'h0, quick_val}, 32'h0);
        rst_n = 1'b1;

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule